// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block gathers interrupt events from a set of transmit queues and from a handful of unrelated sources and turns them into one interrupt line. Per-queue events land in five secondary status registers, one bit per queue per event kind. The primary status register holds no storage for the aggregated kinds. Each of its aggregated bits is computed live as the OR of its group of secondary bits, so it cannot fall out of step with the secondary registers. A few direct event inputs are held in the primary register itself.

Software services an interrupt through a simple register port. It reads the primary register, reads whichever secondary registers are flagged, and writes ones back to clear what it has seen. Writing a one to an aggregated primary bit wipes its whole source group in one access. Events that arrive while software is working are never lost, because only bits written as one are cleared and a new event beats a clear on the same cycle. A primary mask chooses which primary bits may raise the line. A second mask gates the group-2 secondary bits (underrun, host-interface errors and beacon events) before they reach the primary register. A global enable can drop the line at once without touching any status.

Top module: `isa_top`

## Requirements
- R1: After reset all status registers, both masks and the global enable are zero, irq_o and pend_o are low and every register reads as zero.
- R2: An event pulse sets its secondary bit on the next clock edge, and the bit stays set until it is cleared. Secondary 0 holds transmit-done for queue q at bit q and descriptor-done at bit 16+q. Secondary 1 holds transmit-error at q and end-of-list at 16+q. Secondary 2 holds underrun at q, host-interface errors at bits 16 to 18 and beacon events at bits 19 to 24. Secondary 3 holds CBR overrun at q and CBR underrun at 16+q. Secondary 4 holds queue trigger at q.
- R3: The primary aggregated bits read as the OR of their source groups: bit 0 transmit-done, 1 descriptor-done, 2 transmit-error, 3 end-of-list, 7 CBR overrun, 8 CBR underrun and 9 queue trigger. Register reads return the value one clock after the address is presented. The addresses are: primary 0, secondaries 1 to 5, primary mask 6, group-2 mask 7, global enable 8 and pending 9.
- R4: Secondary 2 bits always record events, but they feed primary bit 4 (underrun), bit 5 (host-interface error) and bit 6 (beacon group) only where the group-2 mask bit at the same position is set.
- R5: A write to a secondary register clears exactly the bits written as one and leaves the bits written as zero unchanged.
- R6: Writing one to an aggregated primary bit clears every source bit of its group in the secondary register, whatever the group-2 mask, and leaves the other groups untouched.
- R7: When an event and a clear reach the same bit on the same cycle, the bit ends up set.
- R8: Direct events set primary bits 10 upward, one per input, and these bits are cleared by writing one to them.
- R9: irq_o is high exactly when the global enable (bit 0 of address 8) is on and the primary status ANDed with the primary mask is nonzero. It follows a status or mask change one clock later, and it follows a global enable write on the same edge as the write.
- R10: The pending register reads as exactly 1 while the interrupt is asserted and as 0 otherwise, and pend_o carries the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_txok | input | NQ | Per-queue transmit-done events |
| evt_txdesc | input | NQ | Per-queue descriptor-done events |
| evt_txerr | input | NQ | Per-queue transmit-error events |
| evt_txeol | input | NQ | Per-queue end-of-list events |
| evt_urun | input | NQ | Per-queue underrun events |
| evt_cbro | input | NQ | Per-queue CBR overrun events |
| evt_cbru | input | NQ | Per-queue CBR underrun events |
| evt_trig | input | NQ | Per-queue trigger events |
| evt_hif | input | 3 | Host-interface errors: master abort, system error, data parity |
| evt_bcn | input | 6 | Beacon events: TIM, CAB end, DTIM sync, beacon timeout, CAB timeout, DTIM |
| evt_misc | input | NMISC | Direct primary events |
| irq_o | output | 1 | Interrupt line |
| pend_o | output | 1 | Pending flag |

## Verification
The assertions check on every cycle that write-one-to-clear removes the bits it targets, that an event always survives a clear on the same bit, and that the line stays low while the global enable is off. They also check that it rises one cycle after an unmasked primary bit appears with the enable on. The bench's scenarios are needed for the rest: the bit positions of each group, group clears through the primary register, masking through the group-2 mask, and the exact cycle on which the line reacts to enable, mask and clear writes.

// File: rtl/isa_pkg.sv
package isa_pkg;
  localparam int DW     = 32;
  localparam int AW     = 4;
  localparam int PW     = 16;
  localparam int NSEC   = 5;
  localparam int HI_OFS = 16;
  localparam int HIF_N  = 3;
  localparam int HIF_OFS = 16;
  localparam int BCN_N  = 6;
  localparam int BCN_OFS = 19;

  // primary bit positions
  localparam int P_TXOK   = 0;
  localparam int P_TXDESC = 1;
  localparam int P_TXERR  = 2;
  localparam int P_TXEOL  = 3;
  localparam int P_URUN   = 4;
  localparam int P_HIF    = 5;
  localparam int P_BCN    = 6;
  localparam int P_CBRO   = 7;
  localparam int P_CBRU   = 8;
  localparam int P_TRIG   = 9;
  localparam int P_MISC   = 10;

  // register addresses
  localparam int A_PRIM  = 0;
  localparam int A_SEC0  = 1;
  localparam int A_PMASK = 6;
  localparam int A_SMASK = 7;
  localparam int A_GEN   = 8;
  localparam int A_PEND  = 9;

  typedef logic [NSEC-1:0][DW-1:0] sec_bank_t;
endpackage

// File: rtl/isa_w1c_reg.sv
module isa_w1c_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr) | evt;
  end

  // R5: a one-clear without a competing event removes the bit
  a_r5_clear_takes: assert property (@(posedge clk) disable iff (rst)
    ((clr & ~evt) != '0) |=> ((q & $past(clr & ~evt)) == '0));

  // R7: an event is always held, even against a clear
  a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((q & $past(evt)) == $past(evt)));
endmodule

// File: rtl/isa_aggregate.sv
module isa_aggregate
  import isa_pkg::*;
#(
  parameter int NQ    = 10,
  parameter int NMISC = 3
) (
  input  sec_bank_t         sec,
  input  logic [DW-1:0]     smask,
  input  logic [NMISC-1:0]  misc,
  output logic [PW-1:0]     prim
);
  logic [DW-1:0] s2_gated;
  assign s2_gated = sec[2] & smask;

  always_comb begin
    prim = '0;
    prim[P_TXOK]   = |sec[0][NQ-1:0];
    prim[P_TXDESC] = |sec[0][HI_OFS +: NQ];
    prim[P_TXERR]  = |sec[1][NQ-1:0];
    prim[P_TXEOL]  = |sec[1][HI_OFS +: NQ];
    prim[P_URUN]   = |s2_gated[NQ-1:0];
    prim[P_HIF]    = |s2_gated[HIF_OFS +: HIF_N];
    prim[P_BCN]    = |s2_gated[BCN_OFS +: BCN_N];
    prim[P_CBRO]   = |sec[3][NQ-1:0];
    prim[P_CBRU]   = |sec[3][HI_OFS +: NQ];
    prim[P_TRIG]   = |sec[4][NQ-1:0];
    prim[P_MISC +: NMISC] = misc;
  end
endmodule

// File: rtl/isa_ctrl.sv
module isa_ctrl
  import isa_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] prim,
  output logic [PW-1:0] pmask_q,
  output logic [DW-1:0] smask_q,
  output logic          gen_q,
  output logic          irq_q
);
  logic gen_d;
  assign gen_d = (wr && addr == AW'(A_GEN)) ? wdata[0] : gen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pmask_q <= '0;
      smask_q <= '0;
      gen_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wr && addr == AW'(A_PMASK)) pmask_q <= wdata[PW-1:0];
      if (wr && addr == AW'(A_SMASK)) smask_q <= wdata;
      gen_q <= gen_d;
      irq_q <= gen_d && ((prim & pmask_q) != '0);
    end
  end

  // R9: disabled means silent
  a_r9_gate_off: assert property (@(posedge clk) disable iff (rst)
    !gen_q |-> !irq_q);

  // R9: an unmasked status with enable on raises the line one cycle later
  a_r9_raise: assert property (@(posedge clk) disable iff (rst)
    (gen_q && ($past(prim & pmask_q) != '0)) |-> irq_q);
endmodule

// File: rtl/isa_top.sv
module isa_top
  import isa_pkg::*;
#(
  parameter int NQ    = 10,
  parameter int NMISC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NQ-1:0]     evt_txok,
  input  logic [NQ-1:0]     evt_txdesc,
  input  logic [NQ-1:0]     evt_txerr,
  input  logic [NQ-1:0]     evt_txeol,
  input  logic [NQ-1:0]     evt_urun,
  input  logic [NQ-1:0]     evt_cbro,
  input  logic [NQ-1:0]     evt_cbru,
  input  logic [NQ-1:0]     evt_trig,
  input  logic [HIF_N-1:0]  evt_hif,
  input  logic [BCN_N-1:0]  evt_bcn,
  input  logic [NMISC-1:0]  evt_misc,
  output logic              irq_o,
  output logic              pend_o
);
  localparam int QMAX = HI_OFS;

  sec_bank_t        sec_q, sec_evt, sec_clr, grp_clr;
  logic [PW-1:0]    pclr, prim_live, pmask_q;
  logic [DW-1:0]    smask_q, rdata_d, rdata_q;
  logic [NMISC-1:0] misc_q;
  logic             gen_q, irq_q;

  function automatic logic [DW-1:0] at_lo(input logic [NQ-1:0] v);
    logic [DW-1:0] r;
    r = '0;
    r[NQ-1:0] = v;
    return r;
  endfunction

  function automatic logic [DW-1:0] at_hi(input logic [NQ-1:0] v);
    logic [DW-1:0] r;
    r = '0;
    r[HI_OFS +: NQ] = v;
    return r;
  endfunction

  assign pclr = (reg_wr && reg_addr == AW'(A_PRIM)) ? reg_wdata[PW-1:0] : '0;

  always_comb begin
    sec_evt[0] = at_lo(evt_txok) | at_hi(evt_txdesc);
    sec_evt[1] = at_lo(evt_txerr) | at_hi(evt_txeol);
    sec_evt[2] = at_lo(evt_urun);
    sec_evt[2][HIF_OFS +: HIF_N] = evt_hif;
    sec_evt[2][BCN_OFS +: BCN_N] = evt_bcn;
    sec_evt[3] = at_lo(evt_cbro) | at_hi(evt_cbru);
    sec_evt[4] = at_lo(evt_trig);

    grp_clr[0] = at_lo({NQ{pclr[P_TXOK]}}) | at_hi({NQ{pclr[P_TXDESC]}});
    grp_clr[1] = at_lo({NQ{pclr[P_TXERR]}}) | at_hi({NQ{pclr[P_TXEOL]}});
    grp_clr[2] = at_lo({NQ{pclr[P_URUN]}});
    grp_clr[2][HIF_OFS +: HIF_N] = {HIF_N{pclr[P_HIF]}};
    grp_clr[2][BCN_OFS +: BCN_N] = {BCN_N{pclr[P_BCN]}};
    grp_clr[3] = at_lo({NQ{pclr[P_CBRO]}}) | at_hi({NQ{pclr[P_CBRU]}});
    grp_clr[4] = at_lo({NQ{pclr[P_TRIG]}});
  end

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    assign sec_clr[g] = ((reg_wr && reg_addr == AW'(A_SEC0 + g)) ? reg_wdata : '0)
                        | grp_clr[g];
    isa_w1c_reg #(.W(DW)) u_sec (
      .clk (clk),
      .rst (rst),
      .evt (sec_evt[g]),
      .clr (sec_clr[g]),
      .q   (sec_q[g])
    );
  end

  isa_w1c_reg #(.W(NMISC)) u_misc (
    .clk (clk),
    .rst (rst),
    .evt (evt_misc),
    .clr (pclr[P_MISC +: NMISC]),
    .q   (misc_q)
  );

  isa_aggregate #(.NQ(NQ), .NMISC(NMISC)) u_agg (
    .sec   (sec_q),
    .smask (smask_q),
    .misc  (misc_q),
    .prim  (prim_live)
  );

  isa_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .prim    (prim_live),
    .pmask_q (pmask_q),
    .smask_q (smask_q),
    .gen_q   (gen_q),
    .irq_q   (irq_q)
  );

  always_comb begin
    rdata_d = '0;
    case (reg_addr)
      AW'(A_PRIM):     rdata_d[PW-1:0] = prim_live;
      AW'(A_SEC0):     rdata_d = sec_q[0];
      AW'(A_SEC0 + 1): rdata_d = sec_q[1];
      AW'(A_SEC0 + 2): rdata_d = sec_q[2];
      AW'(A_SEC0 + 3): rdata_d = sec_q[3];
      AW'(A_SEC0 + 4): rdata_d = sec_q[4];
      AW'(A_PMASK):    rdata_d[PW-1:0] = pmask_q;
      AW'(A_SMASK):    rdata_d = smask_q;
      AW'(A_GEN):      rdata_d[0] = gen_q;
      AW'(A_PEND):     rdata_d[0] = irq_q;
      default:         rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;
  assign irq_o     = irq_q;
  assign pend_o    = irq_q;

  initial begin
    a_r2_fit: assert (NQ >= 1 && NQ <= QMAX && NMISC >= 1 && NMISC <= PW - P_MISC);
  end

  // R10: pending never shows without the global enable
  a_r10_pend_needs_enable: assert property (@(posedge clk) disable iff (rst)
    pend_o |-> gen_q);
endmodule

// File: tb/isa_top_tb.sv
module isa_top_tb;
  localparam int NQ = 10;
  localparam int NMISC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NQ-1:0] evt_txok = '0, evt_txdesc = '0, evt_txerr = '0, evt_txeol = '0;
  logic [NQ-1:0] evt_urun = '0, evt_cbro = '0, evt_cbru = '0, evt_trig = '0;
  logic [2:0] evt_hif = '0;
  logic [5:0] evt_bcn = '0;
  logic [NMISC-1:0] evt_misc = '0;
  logic irq_o, pend_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  isa_top #(.NQ(NQ), .NMISC(NMISC)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_txok(evt_txok), .evt_txdesc(evt_txdesc), .evt_txerr(evt_txerr),
    .evt_txeol(evt_txeol), .evt_urun(evt_urun), .evt_cbro(evt_cbro),
    .evt_cbru(evt_cbru), .evt_trig(evt_trig), .evt_hif(evt_hif),
    .evt_bcn(evt_bcn), .evt_misc(evt_misc), .irq_o(irq_o), .pend_o(pend_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic clear_events();
    evt_txok = '0; evt_txdesc = '0; evt_txerr = '0; evt_txeol = '0;
    evt_urun = '0; evt_cbro = '0; evt_cbru = '0; evt_trig = '0;
    evt_hif = '0; evt_bcn = '0; evt_misc = '0;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 10; a++) rd_chk("R1 reset register", 4'(a), 32'h0);
    chk("R1 reset irq", {31'b0, irq_o}, 32'h0);
    chk("R1 reset pend", {31'b0, pend_o}, 32'h0);
  endtask

  task automatic t_set_and_or();
    @(negedge clk); evt_txok[3] = 1'b1;
    @(negedge clk); clear_events();
    rd_chk("R2 txok q3", 4'd1, 32'h0000_0008);
    rd_chk("R3 prim txok", 4'd0, 32'h0000_0001);
    @(negedge clk); evt_txdesc[9] = 1'b1;
    @(negedge clk); clear_events();
    rd_chk("R2 txdesc q9 held with q3", 4'd1, 32'h0200_0008);
    rd_chk("R3 prim txok+txdesc", 4'd0, 32'h0000_0003);
  endtask

  task automatic t_sec_clear();
    @(negedge clk); evt_txok[1] = 1'b1;
    @(negedge clk); clear_events();
    rd_chk("R2 second queue", 4'd1, 32'h0200_000A);
    wr(4'd1, 32'h0000_0008);
    rd_chk("R5 one clears only q3", 4'd1, 32'h0200_0002);
    wr(4'd1, 32'h0000_0000);
    rd_chk("R5 zero write keeps bits", 4'd1, 32'h0200_0002);
  endtask

  task automatic t_group_clear();
    wr(4'd0, 32'h0000_0001);
    rd_chk("R6 txok group cleared", 4'd1, 32'h0200_0000);
    rd_chk("R6 prim after group clear", 4'd0, 32'h0000_0002);
    wr(4'd0, 32'h0000_0002);
    rd_chk("R6 txdesc group cleared", 4'd1, 32'h0000_0000);
  endtask

  task automatic t_group2_mask();
    @(negedge clk); evt_urun[2] = 1'b1; evt_bcn[0] = 1'b1;
    @(negedge clk); clear_events();
    rd_chk("R4 sec2 records while masked", 4'd3, 32'h0008_0004);
    rd_chk("R4 masked sec2 hidden from prim", 4'd0, 32'h0);
    wr(4'd7, 32'h0008_0000);
    rd_chk("R4 beacon bit unmasked", 4'd0, 32'h0000_0040);
    wr(4'd7, 32'hFFFF_FFFF);
    rd_chk("R4 all unmasked", 4'd0, 32'h0000_0050);
    wr(4'd0, 32'h0000_0010);
    rd_chk("R6 underrun group cleared", 4'd3, 32'h0008_0000);
    wr(4'd0, 32'h0000_0040);
    rd_chk("R6 beacon group cleared", 4'd3, 32'h0);
    @(negedge clk); evt_hif[2] = 1'b1;
    @(negedge clk); clear_events();
    rd_chk("R4 parity error to host bit", 4'd0, 32'h0000_0020);
    wr(4'd3, 32'h0004_0000);
    rd_chk("R5 sec2 cleared", 4'd3, 32'h0);
  endtask

  task automatic t_race();
    @(negedge clk);
    evt_txerr[0] = 1'b1; reg_wr = 1'b1; reg_addr = 4'd2; reg_wdata = 32'h1;
    @(negedge clk);
    clear_events(); reg_wr = 1'b0; reg_wdata = '0;
    rd_chk("R7 event beats secondary clear", 4'd2, 32'h0000_0001);
    @(negedge clk); evt_txeol[4] = 1'b1;
    @(negedge clk); clear_events();
    rd_chk("R2 txeol q4", 4'd2, 32'h0010_0001);
    @(negedge clk);
    evt_txeol[5] = 1'b1; reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h8;
    @(negedge clk);
    clear_events(); reg_wr = 1'b0; reg_wdata = '0;
    rd_chk("R7 event beats group clear", 4'd2, 32'h0020_0001);
    rd_chk("R3 prim txerr+txeol", 4'd0, 32'h0000_000C);
    wr(4'd2, 32'hFFFF_FFFF);
    rd_chk("R5 sec1 all cleared", 4'd2, 32'h0);
  endtask

  task automatic t_misc();
    @(negedge clk); evt_misc[1] = 1'b1;
    @(negedge clk); clear_events();
    rd_chk("R8 direct bit", 4'd0, 32'h0000_0800);
    @(negedge clk); evt_cbro[0] = 1'b1; evt_trig[7] = 1'b1; evt_cbru[9] = 1'b1;
    @(negedge clk); clear_events();
    rd_chk("R2 cbr bits", 4'd4, 32'h0200_0001);
    rd_chk("R2 trigger bit", 4'd5, 32'h0000_0080);
    rd_chk("R3 prim cbr+trig+direct", 4'd0, 32'h0000_0B80);
    wr(4'd0, 32'h0000_0B80);
    rd_chk("R8 prim cleared", 4'd0, 32'h0);
    rd_chk("R6 sec3 cleared", 4'd4, 32'h0);
    rd_chk("R6 sec4 cleared", 4'd5, 32'h0);
  endtask

  task automatic t_irq();
    wr(4'd6, 32'h0000_0004);
    wr(4'd8, 32'h1);
    chk("R9 idle with nothing pending", {31'b0, irq_o}, 32'h0);
    @(negedge clk); evt_txerr[6] = 1'b1;
    @(negedge clk); clear_events();
    chk("R9 one cycle latency", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R9 irq raised", {31'b0, irq_o}, 32'h1);
    chk("R10 pend_o", {31'b0, pend_o}, 32'h1);
    rd_chk("R10 pending reads 1", 4'd9, 32'h1);
    wr(4'd8, 32'h0);
    chk("R9 disable immediate", {31'b0, irq_o}, 32'h0);
    rd_chk("R10 pending reads 0 when disabled", 4'd9, 32'h0);
    wr(4'd8, 32'h1);
    chk("R9 enable immediate", {31'b0, irq_o}, 32'h1);
    wr(4'd6, 32'h0);
    @(negedge clk);
    chk("R9 masked off", {31'b0, irq_o}, 32'h0);
    wr(4'd6, 32'h0000_0004);
    @(negedge clk);
    chk("R9 mask back on", {31'b0, irq_o}, 32'h1);
    wr(4'd2, 32'h0000_0040);
    @(negedge clk);
    chk("R9 low after clear", {31'b0, irq_o}, 32'h0);
    @(negedge clk); evt_txok[0] = 1'b1;
    @(negedge clk); clear_events();
    @(negedge clk);
    chk("R9 unmasked kind only", {31'b0, irq_o}, 32'h0);
    rd_chk("R10 pending stays 0", 4'd9, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_set_and_or();
    t_sec_clear();
    t_group_clear();
    t_group2_mask();
    t_race();
    t_misc();
    t_irq();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule